// File: doc/BRIEF.md
# Edge-Triggered Interrupt Vector Controller

This block watches sixteen asynchronous input lines and turns their transitions into interrupt requests. Each line passes through a two-flop synchronizer and an edge detector. A per-line control bit picks whether any transition or only a high-to-low transition counts as an event. Every event sets a sticky pending bit for that line. Software clears a pending bit by writing a one to it.

A per-line enable mask gates the pending bits. The mask comes out of reset disabled, so inputs that float or toggle at power-up cannot raise an interrupt. The highest-numbered enabled pending line is encoded into a fixed six-bit vector. When nothing enabled is pending, the vector holds a dedicated error code. A registered interrupt output is high whenever any enabled line is pending.

Software reaches the control, pending, mask and vector registers through a small word-wide register port. Reads are combinational. Writes take effect at the clock edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the edge-select register (address 0), the pending register (address 1) and the enable mask (address 2) all read 0, the vector register (address 3) reads the error code 0x00, and `irq` is 0.
- R2: When a line's edge-select bit is 0, a rising input transition sets that line's pending bit, and so does a falling input transition.
- R3: When a line's edge-select bit is 1, a rising transition leaves its pending bit at 0, and a falling transition sets it.
- R4: A write to address 1 clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If a new event and a clear of the same line fall in the same clock cycle, the pending bit ends up set.
- R6: `irq` is registered and equals the OR over all lines of (pending AND mask) as of the previous clock edge. A masked pending bit still reads back as 1 at address 1.
- R7: For line n, the vector reads 0x30 + (15 − n), zero-extended to 16 bits at address 3. Line 15 gives 0x30 and line 0 gives 0x3F.
- R8: When several enabled lines are pending, the vector reports the highest-numbered one.
- R9: When no enabled line is pending, the vector reads 0x00. This includes the case where lines are pending but masked.
- R10: Suppose a level change is first sampled at clock edge k. The pending bit reads 0 after edge k+1 and 1 after edge k+2. If the line is enabled, `irq` rises after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 16 | Asynchronous request input lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 edge-select, 1 pending, 2 mask, 3 vector |
| reg_wdata | input | 16 | Write data, one bit per line |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: sixteen lines, a six-bit vector, a vector base of 0x30 and an error code of 0x00. With these values every line's vector from 0x30 to 0x3F can be reached, including both ends of the priority order. The two-stage synchronizer default gives a fixed latency, so the bench can check the exact edges at which pending and `irq` change. That same fixed latency lets it line a clear write up with a detected event on the same edge.

// File: rtl/irqv_pkg.sv
// Package irqv_pkg
// Shared register-port address map for the interrupt vector controller.
// Assumes a two-bit word address on the register port.
package irqv_pkg;
    typedef enum logic [1:0] {
        ADDR_EDGE = 2'd0,
        ADDR_PEND = 2'd1,
        ADDR_MASK = 2'd2,
        ADDR_VEC  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irqv_edge_detect.sv
// Module irqv_edge_detect
// Synchronizes each input line through SYNC_STAGES flops and flags a
// one-cycle event on any transition, or on a falling transition only
// when the line's falling_only bit is set.
// Assumes the inputs are asynchronous and stay stable for at least two clocks.
module irqv_edge_detect #(
    parameter int unsigned N           = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] falling_only_i,
    output logic [N-1:0] evt_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [N-1:0] chain [SYNC_STAGES];
    logic [N-1:0] prev_q;

    // Synchronizer chain plus one history stage used for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= lines_i;
            for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
            prev_q <= chain[LAST];
        end
    end

    // Each line picks its own edge rule.
    for (genvar i = 0; i < N; i++) begin : g_line
        assign evt_o[i] = falling_only_i[i] ? (prev_q[i] & ~chain[LAST][i])
                                            : (prev_q[i] ^ chain[LAST][i]);
    end

    // R3: a falling-only line never reports an event while its synchronized level is high.
    assert_fall_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & falling_only_i & chain[LAST]) == '0));
endmodule

// File: rtl/irqv_pending.sv
// Module irqv_pending
// Sticky pending bits: set by events, cleared by write-one-to-clear.
// A set and a clear of the same bit in one cycle leave it set.
module irqv_pending #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    // Update pending: clear first, then apply new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end

    // R5: every requested set is visible on the next cycle, clear or not.
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R4: a clear that is not overlapped by a set removes the bit.
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irqv_prio_enc.sv
// Module irqv_prio_enc
// Fixed priority encoder: the highest-numbered active request wins and
// maps to VEC_BASE + (N-1-index); no request gives VEC_ERR.
// Assumes VEC_BASE + N - 1 fits in VEC_W bits and differs from VEC_ERR.
module irqv_prio_enc #(
    parameter int unsigned N        = 16,
    parameter int unsigned VEC_W    = 6,
    parameter int unsigned VEC_BASE = 48,
    parameter int unsigned VEC_ERR  = 0
) (
    input  logic [N-1:0]     req_i,
    output logic [VEC_W-1:0] vec_o
);
    // Scan upward so the last (highest) active line overrides lower ones.
    always_comb begin
        vec_o = VEC_W'(VEC_ERR);
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) vec_o = VEC_W'(VEC_BASE + N - 1 - i);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module irq_vector_ctrl
// Top of the edge-triggered interrupt vector controller: holds the
// edge-select and mask registers, the register read mux and the
// registered interrupt output. Synchronous active-low reset.
// Assumes reg_rdata is sampled combinationally within the same cycle.
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 16,
    parameter int unsigned VEC_W       = 6,
    parameter int unsigned VEC_BASE    = 48,
    parameter int unsigned VEC_ERR     = 0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic                 irq
);
    localparam logic [VEC_W-1:0] ERR_CODE = VEC_W'(VEC_ERR);

    reg_addr_e            sel;
    logic [NUM_LINES-1:0] edge_sel_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] evt;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] clr;
    logic [NUM_LINES-1:0] active;
    logic [VEC_W-1:0]     vec;

    assign sel    = reg_addr_e'(reg_addr);
    assign clr    = (reg_wr && sel == ADDR_PEND) ? reg_wdata : '0;
    assign active = pend & mask_q;

    irqv_edge_detect #(.N(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk            (clk),
        .rst_n          (rst_n),
        .lines_i        (line_in),
        .falling_only_i (edge_sel_q),
        .evt_o          (evt)
    );

    irqv_pending #(.N(NUM_LINES)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irqv_prio_enc #(.N(NUM_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_ERR(VEC_ERR)) u_enc (
        .req_i (active),
        .vec_o (vec)
    );

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel_q <= '0;
            mask_q     <= '0;
        end else if (reg_wr) begin
            if (sel == ADDR_EDGE) edge_sel_q <= reg_wdata;
            if (sel == ADDR_MASK) mask_q     <= reg_wdata;
        end
    end

    // Registered interrupt request from the enabled pending lines.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |active;
    end

    // Read mux; the vector is zero-extended to the port width.
    always_comb begin
        unique case (sel)
            ADDR_EDGE: reg_rdata = edge_sel_q;
            ADDR_PEND: reg_rdata = pend;
            ADDR_MASK: reg_rdata = mask_q;
            ADDR_VEC:  reg_rdata = NUM_LINES'(vec);
            default:   reg_rdata = '0;
        endcase
    end

    // R1: the enable mask leaves reset all-disabled.
    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '0));

    // R9: the encoder reports the error code exactly when no enabled line is pending.
    assert_err_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(pend & mask_q)) == (vec != ERR_CODE)));

    // R6: a raised irq follows a cycle in which the vector named a line.
    assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(vec) != ERR_CODE));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] line_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic toggle(input int n);
        @(negedge clk);
        line_in[n] = ~line_in[n];
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        @(negedge clk);
        rd(2'd0, d); chk("R1 edge-select", d, 16'h0);
        rd(2'd1, d); chk("R1 pending", d, 16'h0);
        rd(2'd2, d); chk("R1 mask", d, 16'h0);
        rd(2'd3, d); chk("R1 vector", d, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_any_change();
        logic [15:0] d;
        wr(2'd0, 16'h0000);
        toggle(3);
        rd(2'd1, d); chk("R2 rising", d, 16'h0008);
        wr(2'd1, 16'hFFFF);
        toggle(3);
        rd(2'd1, d); chk("R2 falling", d, 16'h0008);
        wr(2'd1, 16'hFFFF);
    endtask

    task automatic t_falling();
        logic [15:0] d;
        wr(2'd0, 16'h0020);
        toggle(5);
        rd(2'd1, d); chk("R3 rising ignored", d, 16'h0000);
        toggle(5);
        rd(2'd1, d); chk("R3 falling", d, 16'h0020);
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        toggle(1);
        toggle(2);
        rd(2'd1, d); chk("R4 setup", d, 16'h0006);
        wr(2'd1, 16'h0002);
        rd(2'd1, d); chk("R4 clear one", d, 16'h0004);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); chk("R4 zero write", d, 16'h0004);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); chk("R4 clear all", d, 16'h0000);
    endtask

    task automatic t_latency();
        logic [15:0] d;
        wr(2'd2, 16'h0080);
        @(negedge clk);
        line_in[7] = ~line_in[7];            // sampled at edge k
        @(posedge clk); @(posedge clk);       // k, k+1
        @(negedge clk);
        rd(2'd1, d); chk("R10 pending after k+1", d, 16'h0000);
        @(negedge clk);                       // after k+2
        rd(2'd1, d); chk("R10 pending after k+2", d, 16'h0080);
        chk("R10 irq after k+2", {15'd0, irq}, 16'h0);
        @(negedge clk);                       // after k+3
        chk("R10 irq after k+3", {15'd0, irq}, 16'h1);
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        @(negedge clk);
        line_in[9] = ~line_in[9];            // sampled at edge k
        @(negedge clk);                      // after k
        @(negedge clk);                      // after k+1
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0200;   // hits edge k+2
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd1, d); chk("R5 set beats clear", d, 16'h0200);
        wr(2'd1, 16'hFFFF);
    endtask

    task automatic t_mask_irq();
        logic [15:0] d;
        wr(2'd2, 16'h0000);
        toggle(11);
        rd(2'd1, d); chk("R6 masked still pending", d, 16'h0800);
        chk("R6 masked no irq", {15'd0, irq}, 16'h0);
        rd(2'd3, d); chk("R9 masked gives error", d, 16'h0000);
        wr(2'd2, 16'h0800);
        @(negedge clk);
        chk("R6 enabled irq", {15'd0, irq}, 16'h1);
        rd(2'd3, d); chk("R7 line 11 vector", d, 16'h0034);
        wr(2'd1, 16'hFFFF);
        @(negedge clk);
        chk("R6 irq drops", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_vectors();
        logic [15:0] d;
        wr(2'd2, 16'hFFFF);
        for (int n = 0; n < 16; n++) begin
            toggle(n);
            rd(2'd3, d); chk($sformatf("R7 line %0d", n), d, 16'(48 + 15 - n));
            wr(2'd1, 16'hFFFF);
        end
        toggle(0);
        toggle(15);
        rd(2'd3, d); chk("R8 15 over 0", d, 16'h0030);
        wr(2'd2, 16'h7FFF);
        rd(2'd3, d); chk("R8 masked 15 falls to 0", d, 16'h003F);
        wr(2'd1, 16'hFFFF);
        toggle(4);
        toggle(10);
        rd(2'd3, d); chk("R8 10 over 4", d, 16'h0035);
        wr(2'd1, 16'hFFFF);
        rd(2'd3, d); chk("R9 empty gives error", d, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_any_change();
        t_falling();
        t_w1c();
        t_latency();
        t_set_wins();
        t_mask_irq();
        t_vectors();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule